// File: doc/BRIEF.md
# Serial Bus Hold Gate

This block sits beside the serial shifter of a flash slave. It lets the bus master pause a transfer by pulling the hold pin low, and it leaves any internal program, erase or status write that is already running untouched. It watches the serial clock, the active-low chip select, the active-low hold pin and the busy flag of the program and erase engine. It produces a clock enable for the shifter, an output-enable mask for the serial data output and a one-cycle request to reset the interface logic.

The pins are assumed to be synchronized to the system clock `clk` before they reach this block. A hold takes effect, and is released, only once the serial clock has been seen low. While a hold is in force the shifter receives no clock enables, so its bit count and partial data stay where they were, and the transfer resumes from that point. If chip select rises during a hold, the block asks for an interface reset and keeps the bus gated until hold is high and chip select is idle. In quad modes the hold pin carries data, so a mode input turns hold detection off.

Top module: `busHoldGate`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `shiftEn`, `soOe`, `ifReset` and `engineRun` are 0 and the block is not holding.
- R2: A high-to-low change of `holdN` that is sampled while `csN` is low starts a hold. If `sclk` is low at that sample, `soOe` and `shiftEn` are forced to 0 from the second cycle after the sample. If `sclk` is high, the hold waits until `sclk` is sampled low, and the gating then follows with the same two-cycle delay.
- R3: While holding, a 0-to-1 change of `sclk` produces no `shiftEn` pulse. Outside a hold, each such change sampled with `csN` low gives exactly one `shiftEn` pulse, one cycle after the sample.
- R4: While holding, `soOe` is 0. Outside a hold, `soOe` equals the inverse of the `csN` value sampled one cycle earlier.
- R5: A hold is released when `holdN` is sampled high together with `sclk` low. If `sclk` is high, the release waits until `sclk` is sampled low. If `holdN` falls again before then, the hold stays in force.
- R6: A hold that is in force and sees `csN` sampled high raises `ifReset` for exactly one cycle. The gating then stays on until `holdN` and `csN` are sampled high in the same cycle.
- R7: `engineRun` equals the value of `busy` sampled one cycle earlier, whatever the hold state is and whether or not an interface reset occurs.
- R8: While `quadMode` is 1, changes of `holdN` start no hold, and any hold in progress is cancelled at the next clock edge.
- R9: A falling edge of `holdN` that is sampled while `csN` is high starts no hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Synchronized serial clock |
| csN | input | 1 | Synchronized chip select, active low |
| holdN | input | 1 | Synchronized hold pin, active low |
| busy | input | 1 | Program/erase/status-write engine running |
| quadMode | input | 1 | Hold pin is used as data; hold detection is off |
| shiftEn | output | 1 | One-cycle clock enable for the serial shifter |
| soOe | output | 1 | Output enable for the serial data output |
| ifReset | output | 1 | One-cycle interface reset request |
| engineRun | output | 1 | Registered busy flag; never paused by a hold |

## Verification
The risky coincidences are a chip-select rise landing in the same cycle as a hold release (or as a hold re-assertion while a release is pending), and a serial clock rise landing in the same cycle as a hold falling edge. The random stimulus toggles all pins in the same cycle often, and directed sequences force both cases. A cycle-accurate reference model in the bench predicts every output on every cycle. In that model a chip-select rise takes priority over a release and leads to one reset pulse. A clock rise that meets a deferred hold still produces its shift enable.

// File: rtl/busHoldPkg.sv
package busHoldPkg;

  typedef enum logic [2:0] {
    ST_ACTIVE      = 3'd0,
    ST_HOLD_WAIT   = 3'd1,
    ST_HELD        = 3'd2,
    ST_RELEASE_WAIT= 3'd3,
    ST_LOCKED      = 3'd4
  } holdState_e;

  // observations from the datapath to the control
  typedef struct packed {
    logic holdFall;
    logic holdHigh;
    logic sclkLow;
    logic csHigh;
  } pinEvent_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic gate;
    logic resetReq;
  } ctrlStrobe_t;

endpackage

// File: rtl/holdCtrl.sv
module holdCtrl
  import busHoldPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        quadMode,
  input  pinEvent_t   ev,
  output ctrlStrobe_t strobe
);

  holdState_e state, stateNext;
  logic inHold;

  assign inHold = (state == ST_HELD) || (state == ST_RELEASE_WAIT);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ACTIVE: begin
        if (ev.holdFall && !ev.csHigh)
          stateNext = ev.sclkLow ? ST_HELD : ST_HOLD_WAIT;
      end
      ST_HOLD_WAIT: begin
        if (ev.csHigh || ev.holdHigh) stateNext = ST_ACTIVE;
        else if (ev.sclkLow)          stateNext = ST_HELD;
      end
      ST_HELD: begin
        if (ev.csHigh)        stateNext = ST_LOCKED;
        else if (ev.holdHigh) stateNext = ev.sclkLow ? ST_ACTIVE : ST_RELEASE_WAIT;
      end
      ST_RELEASE_WAIT: begin
        if (ev.csHigh)         stateNext = ST_LOCKED;
        else if (!ev.holdHigh) stateNext = ST_HELD;
        else if (ev.sclkLow)   stateNext = ST_ACTIVE;
      end
      ST_LOCKED: begin
        if (ev.holdHigh && ev.csHigh) stateNext = ST_ACTIVE;
      end
      default: stateNext = ST_ACTIVE;
    endcase
    if (quadMode) stateNext = ST_ACTIVE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ACTIVE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.gate     = inHold || (state == ST_LOCKED);
    strobe.resetReq = inHold && ev.csHigh && !quadMode;
  end

  // R8: quad mode cancels any hold at the next edge
  p_quad_cancels_r8: assert property (@(posedge clk) disable iff (!rstN)
    quadMode |=> (state == ST_ACTIVE));

  // R6: a reset request always lands the control in the locked state
  p_reset_locks_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.resetReq |=> (state == ST_LOCKED));

  // R2: a deferred hold waits while the serial clock stays high
  p_defer_entry_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD_WAIT && !ev.sclkLow && !ev.csHigh && !ev.holdHigh && !quadMode)
      |=> (state == ST_HOLD_WAIT));

  // R5: a deferred release waits while the serial clock stays high
  p_defer_exit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE_WAIT && !ev.sclkLow && !ev.csHigh && ev.holdHigh && !quadMode)
      |=> (state == ST_RELEASE_WAIT));

endmodule

// File: rtl/holdDatapath.sv
module holdDatapath
  import busHoldPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        holdN,
  input  logic        busy,
  input  ctrlStrobe_t strobe,
  output pinEvent_t   ev,
  output logic        shiftEn,
  output logic        soOe,
  output logic        ifReset,
  output logic        engineRun
);

  logic sclkQ, holdQ;
  logic sclkRise;

  assign sclkRise    = sclk && !sclkQ;
  assign ev.holdFall = holdQ && !holdN;
  assign ev.holdHigh = holdN;
  assign ev.sclkLow  = !sclk;
  assign ev.csHigh   = csN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      holdQ     <= 1'b1;
      shiftEn   <= 1'b0;
      soOe      <= 1'b0;
      ifReset   <= 1'b0;
      engineRun <= 1'b0;
    end else begin
      sclkQ     <= sclk;
      holdQ     <= holdN;
      shiftEn   <= sclkRise && !csN && !strobe.gate;
      soOe      <= !csN && !strobe.gate;
      ifReset   <= strobe.resetReq;
      engineRun <= busy;
    end
  end

  // R3: no shift enable is issued out of a gated cycle
  p_no_shift_gated_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gate |=> !shiftEn);

  // R4: output stays disabled behind a gated cycle
  p_oe_off_gated_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.gate |=> !soOe);

  // R6: the interface reset is a single-cycle pulse
  p_reset_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    ifReset |=> !ifReset);

endmodule

// File: rtl/busHoldGate.sv
module busHoldGate
  import busHoldPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic sclk,
  input  logic csN,
  input  logic holdN,
  input  logic busy,
  input  logic quadMode,
  output logic shiftEn,
  output logic soOe,
  output logic ifReset,
  output logic engineRun
);

  pinEvent_t   ev;
  ctrlStrobe_t strobe;

  holdCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .quadMode (quadMode),
    .ev       (ev),
    .strobe   (strobe)
  );

  holdDatapath uPath (
    .clk       (clk),
    .rstN      (rstN),
    .sclk      (sclk),
    .csN       (csN),
    .holdN     (holdN),
    .busy      (busy),
    .strobe    (strobe),
    .ev        (ev),
    .shiftEn   (shiftEn),
    .soOe      (soOe),
    .ifReset   (ifReset),
    .engineRun (engineRun)
  );

endmodule

// File: tb/busHoldGate_test.sv
module busHoldGate_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, holdN = 1'b1, busy = 1'b0, quadMode = 1'b0;
  logic shiftEn, soOe, ifReset, engineRun;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // reference model state: 0 active,1 hold wait,2 held,3 release wait,4 locked
  int mState = 0;
  logic mPrevSclk = 1'b0, mPrevHold = 1'b1;

  always #5 clk = ~clk;

  busHoldGate uut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .holdN(holdN),
    .busy(busy), .quadMode(quadMode), .shiftEn(shiftEn), .soOe(soOe),
    .ifReset(ifReset), .engineRun(engineRun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextState(int st, logic s, logic c, logic h, logic q, logic hFall);
    int n = st;
    case (st)
      0: if (hFall && !c) n = s ? 1 : 2;
      1: if (c || h) n = 0; else if (!s) n = 2;
      2: if (c) n = 4; else if (h) n = s ? 3 : 0;
      3: if (c) n = 4; else if (!h) n = 2; else if (!s) n = 0;
      4: if (h && c) n = 0;
      default: n = 0;
    endcase
    if (q) n = 0;
    return n;
  endfunction

  // drive one cycle of pins, then compare every output with the model
  task automatic step(input logic s, input logic c, input logic h, input logic b, input logic q);
    logic gated, eShift, eOe, eRst;
    @(negedge clk);
    sclk = s; csN = c; holdN = h; busy = b; quadMode = q;
    @(posedge clk);
    #2;
    gated  = (mState >= 2);
    eShift = s && !mPrevSclk && !c && !gated;
    eOe    = !c && !gated;
    eRst   = (mState == 2 || mState == 3) && c && !q;
    mState = nextState(mState, s, c, h, q, mPrevHold && !h);
    mPrevSclk = s;
    mPrevHold = h;
    chk(shiftEn == eShift, "R3 shiftEn", shiftEn, eShift);
    chk(soOe == eOe, "R4 soOe", soOe, eOe);
    chk(ifReset == eRst, "R6 ifReset", ifReset, eRst);
    chk(engineRun == b, "R7 engineRun", engineRun, b);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    chk(shiftEn == 0 && soOe == 0 && ifReset == 0 && engineRun == 0, "R1 reset outputs",
        {shiftEn, soOe, ifReset, engineRun}, 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #2;
    chk(soOe == 0 && shiftEn == 0, "R1 first cycle", {shiftEn, soOe}, 0);

    // R2 immediate entry with sclk low
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(soOe == 1, "R2 not yet gated", soOe, 1);
    step(0, 0, 0, 0, 0);
    chk(soOe == 0, "R2 gated after entry", soOe, 0);
    // R3 clock rise while held
    step(1, 0, 0, 1, 0);
    chk(shiftEn == 0, "R3 rise ignored in hold", shiftEn, 0);
    // R5 deferred release: hold high with sclk high
    step(1, 0, 1, 1, 0);
    step(1, 0, 1, 1, 0);
    chk(soOe == 0, "R5 release deferred", soOe, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(soOe == 1, "R5 released", soOe, 1);
    step(1, 0, 1, 0, 0);
    chk(shiftEn == 1, "R3 rise after release", shiftEn, 1);

    // R2 deferred entry: hold falls with sclk high, same cycle as nothing else
    step(1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    chk(soOe == 1, "R2 entry deferred", soOe, 1);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(soOe == 0, "R2 deferred entry taken", soOe, 0);

    // R6 chip select rises together with hold release
    step(0, 1, 1, 1, 0);
    chk(ifReset == 1, "R6 reset pulse", ifReset, 1);
    chk(engineRun == 1, "R7 busy kept through reset", engineRun, 1);
    step(0, 0, 1, 1, 0);
    chk(ifReset == 0, "R6 pulse one cycle", ifReset, 0);
    step(0, 0, 1, 1, 0);
    chk(soOe == 0, "R6 locked while cs low", soOe, 0);
    step(0, 1, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 1, 0, 0);
    chk(soOe == 1, "R6 restart after idle", soOe, 1);

    // R8 quad mode ignores hold
    step(0, 0, 1, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    chk(soOe == 1, "R8 hold ignored in quad", soOe, 1);
    step(0, 0, 1, 0, 0);

    // R9 hold fall while deselected
    step(0, 1, 1, 0, 0);
    step(0, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    chk(soOe == 1, "R9 no hold when deselected", soOe, 1);
    step(0, 0, 1, 0, 0);

    // random mix, biased so holds and selects stay long enough to matter
    for (int i = 0; i < 4000; i++) begin
      logic s, c, h, b, q;
      s = $urandom_range(0, 1);
      c = ($urandom_range(0, 9) == 0) ? ~csN : csN;
      h = ($urandom_range(0, 5) == 0) ? ~holdN : holdN;
      b = ($urandom_range(0, 3) == 0) ? ~busy : busy;
      q = ($urandom_range(0, 40) == 0) ? ~quadMode : quadMode;
      step(s, c, h, b, q);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule